// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block controls a port of up to 32 I/O pins through a small memory-mapped register file. Every pin has seven control attributes, each held as one bit in a per-attribute status vector: ownership (GPIO logic or a peripheral), peripheral choice (function A or B), output enable, output data, pull-up request, open-drain mode and input glitch-filter enable.

Software never does read-modify-write on these bits. Each attribute has a write-only set address and a write-only clear address. A write to one of them changes exactly the bits that are 1 in the written mask. A pin index therefore maps to the mask bit (index mod 32). The status vector of each attribute can be read at a third address. The live pad level of all pins can be read at a separate address.

The pad side is modelled as plain vectors. A three-way mux picks the driver of each pin: the GPIO data and enable bits, peripheral A, or peripheral B. The open-drain stage then acts on whichever driver won. The pull-up and filter-enable bits are exported for the pad cell and for input logic elsewhere.

Top module: `pcb_port`

## Requirements
- R1: After reset every pin is GPIO-owned, the peripheral choice is A, output enables are 0, output data is 0, pull-ups are 1, and open-drain and filter bits are 0.
- R2: A write to an attribute's set address sets the bits that are 1 in the write data and leaves all other bits of that attribute, and all other attributes, unchanged.
- R3: A write to an attribute's clear address clears the bits that are 1 in the write data and leaves all other bits unchanged.
- R4: For a GPIO-owned pin (ownership bit 1), the driven value is its output data bit and the drive enable is its output-enable bit.
- R5: For a peripheral-owned pin, the driver is peripheral A when its choice bit is 0 and peripheral B when it is 1.
- R6: When a pin's open-drain bit is 1, pad_out is 0 and pad_oe equals the selected enable AND NOT the selected value. When the bit is 0, pad_out and pad_oe follow the selected driver directly.
- R7: A read of the pad-level address (word 21) returns pad_in for every pin, whatever its ownership.
- R8: A read of a status address returns that attribute's vector. Reads of set, clear or unmapped addresses (22 and above) return 0.
- R9: pullup_req equals the pull-up status vector and filt_en equals the filter status vector at all times.
- R10: The address map is as follows. Attribute k has its set address at word 3k, its clear address at 3k+1 and its status address at 3k+2. The attribute order is: ownership (0), peripheral choice (1), output enable (2), output data (3), pull-up (4), open-drain (5), filter (6).
- R11: Writes take effect on the clock edge on which bus_wr is sampled high. Reads are combinational from bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Live pad levels |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Pad drive enables |
| pa_out | input | 32 | Peripheral A output values |
| pa_oe | input | 32 | Peripheral A drive enables |
| pb_out | input | 32 | Peripheral B output values |
| pb_oe | input | 32 | Peripheral B drive enables |
| pullup_req | output | 32 | Per-pin pull-up requests |
| filt_en | output | 32 | Per-pin glitch-filter enables |

## Verification
Random set and clear writes use masks that mix single bits, all-ones, zero and dense random patterns. Checking every status vector after each write separates a correct masked update from a whole-word overwrite and from a write that lands on the wrong attribute. Random peripheral and pad inputs are applied under random ownership, choice and open-drain states, so each leg of the driver mux and of the open-drain stage is exercised and told apart from the others. Directed cases cover the reset values, a zero mask, a pin index above 31, a pad read while the pins are peripheral-owned, and reads of set, clear and unmapped addresses.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int NUM_ATTR = 7;
  localparam int AT_OWN = 0;
  localparam int AT_SELB = 1;
  localparam int AT_OE = 2;
  localparam int AT_DAT = 3;
  localparam int AT_PU = 4;
  localparam int AT_OD = 5;
  localparam int AT_FLT = 6;
  localparam int PAD_LEVEL_WORD = 3 * NUM_ATTR;

  function automatic int set_word(input int k);
    return 3 * k;
  endfunction

  function automatic int clr_word(input int k);
    return 3 * k + 1;
  endfunction

  function automatic int stat_word(input int k);
    return 3 * k + 2;
  endfunction

  // returns {value, enable} seen at one pad
  function automatic logic [1:0] pad_drive(input logic own, input logic selb,
      input logic oe, input logic dat, input logic od,
      input logic ao, input logic ae, input logic bo, input logic be);
    logic v, e;
    if (own) begin
      v = dat; e = oe;
    end else if (selb) begin
      v = bo; e = be;
    end else begin
      v = ao; e = ae;
    end
    if (od) return {1'b0, e & ~v};
    return {v, e};
  endfunction
endpackage

// File: rtl/pcb_attr_reg.sv
module pcb_attr_reg #(
  parameter int N = 32,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RST;
    else if (set_stb) state <= state | wmask;
    else if (clr_stb) state <= state & ~wmask;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((state & $past(wmask)) == $past(wmask)) &&
                ((state & ~$past(wmask)) == ($past(state) & ~$past(wmask))));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((state & $past(wmask)) == '0) &&
                ((state & ~$past(wmask)) == ($past(state) & ~$past(wmask))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(state));
endmodule

// File: rtl/pcb_wr_decode.sv
module pcb_wr_decode #(
  parameter int ADDR_W = 5,
  parameter int NA = pcb_pkg::NUM_ATTR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NA-1:0]     set_stb,
  output logic [NA-1:0]     clr_stb
);
  import pcb_pkg::*;

  for (genvar k = 0; k < NA; k++) begin : g_dec
    assign set_stb[k] = wr && (addr == ADDR_W'(set_word(k)));
    assign clr_stb[k] = wr && (addr == ADDR_W'(clr_word(k)));
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb}));

  assert_no_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> ({set_stb, clr_stb} == '0));
endmodule

// File: rtl/pcb_pad_mux.sv
module pcb_pad_mux #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] own,
  input  logic [N-1:0] selb,
  input  logic [N-1:0] oe,
  input  logic [N-1:0] dat,
  input  logic [N-1:0] od,
  input  logic [N-1:0] pa_out,
  input  logic [N-1:0] pa_oe,
  input  logic [N-1:0] pb_out,
  input  logic [N-1:0] pb_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  import pcb_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [1:0] drv;
    assign drv = pad_drive(own[i], selb[i], oe[i], dat[i], od[i],
                           pa_out[i], pa_oe[i], pb_out[i], pb_oe[i]);
    assign pad_out[i] = drv[1];
    assign pad_oe[i]  = drv[0];
  end

  // open-drain pins never drive a high level
  assert_od_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od) == '0);

  assert_gpio_pp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ dat) & own & ~od) == '0 && ((pad_oe ^ oe) & own & ~od) == '0);

  assert_periph_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ pa_oe) & ~own & ~selb & ~od) == '0);
endmodule

// File: rtl/pcb_port.sv
module pcb_port #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  input  logic [N_PINS-1:0] pa_out,
  input  logic [N_PINS-1:0] pa_oe,
  input  logic [N_PINS-1:0] pb_out,
  input  logic [N_PINS-1:0] pb_oe,
  output logic [N_PINS-1:0] pullup_req,
  output logic [N_PINS-1:0] filt_en
);
  import pcb_pkg::*;
  localparam int NA = NUM_ATTR;
  localparam logic [NA-1:0] ONES_AT_RESET = NA'((1 << AT_OWN) | (1 << AT_PU));

  logic [NA-1:0] set_stb, clr_stb;
  logic [NA-1:0][N_PINS-1:0] stat;

  pcb_wr_decode #(.ADDR_W(ADDR_W), .NA(NA)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .set_stb(set_stb), .clr_stb(clr_stb)
  );

  for (genvar k = 0; k < NA; k++) begin : g_attr
    pcb_attr_reg #(.N(N_PINS), .RST({N_PINS{ONES_AT_RESET[k]}})) u_reg (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb[k]), .clr_stb(clr_stb[k]),
      .wmask(bus_wdata), .state(stat[k])
    );
  end

  pcb_pad_mux #(.N(N_PINS)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .own(stat[AT_OWN]), .selb(stat[AT_SELB]), .oe(stat[AT_OE]),
    .dat(stat[AT_DAT]), .od(stat[AT_OD]),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pullup_req = stat[AT_PU];
  assign filt_en    = stat[AT_FLT];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(PAD_LEVEL_WORD)) bus_rdata = pad_in;
    for (int k = 0; k < NA; k++)
      if (bus_addr == ADDR_W'(stat_word(k))) bus_rdata = stat[k];
  end

  assert_pad_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(PAD_LEVEL_WORD)) |-> (bus_rdata == pad_in));

  assert_wo_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(set_word(AT_OE)) || bus_addr == ADDR_W'(clr_word(AT_OE)))
      |-> (bus_rdata == '0));

  assert_pu_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb[AT_PU] |=> ((pullup_req & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

// File: tb/pcb_port_test.sv
module pcb_port_test;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pad_in = 0, pad_out, pad_oe;
  logic [31:0] pa_out = 0, pa_oe = 0, pb_out = 0, pb_oe = 0;
  logic [31:0] pullup_req, filt_en;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_st [7];

  always #10 clk = ~clk;

  pcb_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int idx);
    return 32'h1 << (idx % 32);
  endfunction

  task automatic bus_write(input int a, input logic [31:0] m);
    @(negedge clk);
    bus_wr = 1; bus_addr = 5'(a); bus_wdata = m;
    @(negedge clk);
    bus_wr = 0;
    if (a < 21) begin
      if (a % 3 == 0) exp_st[a/3] = exp_st[a/3] | m;
      else if (a % 3 == 1) exp_st[a/3] = exp_st[a/3] & ~m;
    end
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic check_status(input string req);
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      bus_read(3*k + 2, d);
      chk(req, d, exp_st[k]);
    end
    chk("R9 pullup", pullup_req, exp_st[4]);
    chk("R9 filter", filt_en, exp_st[6]);
  endtask

  task automatic check_pads();
    logic [31:0] eo, ee;
    for (int i = 0; i < 32; i++) begin
      logic v, e;
      case ({exp_st[0][i], exp_st[1][i]})
        2'b10, 2'b11: begin v = exp_st[3][i]; e = exp_st[2][i]; end
        2'b01:        begin v = pb_out[i]; e = pb_oe[i]; end
        default:      begin v = pa_out[i]; e = pa_oe[i]; end
      endcase
      eo[i] = exp_st[5][i] ? 1'b0 : v;
      ee[i] = exp_st[5][i] ? (e & ~v) : e;
    end
    #1;
    chk("R4 R5 R6 pad_out", pad_out, eo);
    chk("R4 R5 R6 pad_oe", pad_oe, ee);
  endtask

  function automatic logic [31:0] rnd_mask();
    case ($urandom % 5)
      0: return 32'h1 << ($urandom % 32);
      1: return 32'hFFFF_FFFF;
      2: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    exp_st[0] = '1; exp_st[1] = '0; exp_st[2] = '0; exp_st[3] = '0;
    exp_st[4] = '1; exp_st[5] = '0; exp_st[6] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_status("R1 reset status");
    check_pads();

    // R2 zero mask changes nothing
    bus_write(6, 32'h0);
    check_status("R2 zero mask");
    // R10 pin index 37 maps to bit 5 of output enable
    bus_write(6, mask_of(37));
    check_status("R10 index mod 32");
    bus_write(9, 32'hFFFF_FFFF);
    check_pads();
    bus_write(10, 32'h0000_00F0);
    check_status("R3 clear data");
    check_pads();

    // R7 pad read while all pins are peripheral-owned
    bus_write(1, 32'hFFFF_FFFF);
    pad_in = 32'hA5C3_0F96;
    bus_read(21, d);
    chk("R7 pad level", d, 32'hA5C3_0F96);
    // R8 write-only and unmapped addresses read 0
    for (int a = 0; a < 21; a += 3) begin
      bus_read(a, d);     chk("R8 set reads 0", d, 0);
      bus_read(a + 1, d); chk("R8 clr reads 0", d, 0);
    end
    for (int a = 22; a < 32; a++) begin
      bus_read(a, d); chk("R8 unmapped reads 0", d, 0);
    end

    // R2 R3 R11 random masked writes
    for (int it = 0; it < 400; it++) begin
      int k;
      k = $urandom % 7;
      bus_write(3*k + ($urandom % 2), rnd_mask());
      pa_out = $urandom; pa_oe = $urandom; pb_out = $urandom; pb_oe = $urandom;
      pad_in = $urandom;
      check_status("R2 R3 random status");
      check_pads();
      bus_read(21, d);
      chk("R7 random pad level", d, pad_in);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule